// File: doc/BRIEF.md
# Serial memory two-wire slave engine

This block is the bus-facing half of a 2 KiB serial memory. It oversamples the two-wire clock and data lines with a fast system clock and detects START and STOP conditions. It shifts bytes in and out MSB first and answers with an acknowledge on the ninth clock. It drives the data line only through an open-drain pull-down enable. The first byte after a START carries a fixed marker bit, three chip-select bits and three block bits, then the read/write flag. The block bits become the top three bits of an 11-bit address pointer.

Write traffic leaves the engine as one strobe per accepted data byte, with address and data, towards a page buffer. A second strobe at STOP asks the storage side to start its timed write. While the storage side reports busy, the engine acknowledges nothing, so a master can poll for the end of a write. Read data is taken from a combinational read port addressed by the pointer. The storage array, write timing and analog input filtering sit outside this block.

Top module: `i2cs_slave`

## Requirements
- R1: A START (SDA falling while SCL is high) clears any partly received byte and makes the engine expect a control byte. A STOP (SDA rising while SCL is high) returns it to idle. SDA changes while SCL is high never count as data bits, and the engine does not drive SDA while idle.
- R2: The control byte is checked MSB first: bit 7 must be 1; bits 6, 5 and 4 must equal chip_sel_i[2], the inverse of chip_sel_i[1], and chip_sel_i[0]. On a mismatch no ACK is given, and later bytes are neither acknowledged nor acted on until the next START.
- R3: Each accepted byte (control, word address, write data) is acknowledged by driving sda_oe_o high for the whole high phase of the ninth SCL pulse.
- R4: While busy_i is high, no byte is acknowledged and no write strobe is issued; once busy_i is low, the same control byte is acknowledged.
- R5: A write control byte (bit 0 = 0) loads bits 3..1 into pointer bits [10:8], and the next byte loads pointer bits [7:0]. Each later data byte gives a one-cycle wr_en_o with wr_addr_o equal to the pointer and wr_data_o equal to the byte.
- R6: After each written byte, only pointer bits [3:0] advance, wrapping inside the 16-byte page; bits [10:4] stay constant.
- R7: A STOP that ends a write carrying at least one data byte gives exactly one one-cycle commit_o pulse. A repeated START, or a STOP after a write with no data byte, gives none.
- R8: A read control byte (bit 0 = 1) loads pointer bits [10:8], is acknowledged, and is followed by the byte at the pointer, MSB first. The pointer advances by one after each byte sent, so a following current-address read returns the next location.
- R9: A master ACK after a read byte brings the next sequential byte, with the pointer wrapping from 0x7FF to 0x000. A master NACK ends the read, and SDA stays released until the next START.
- R10: Every change of sda_oe_o takes place while SCL is low, at least DRIVE_DLY system clocks after the SCL fall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, many times the SCL rate |
| rst_ni | input | 1 | Active-low reset, asserted asynchronously, released synchronously |
| scl_i | input | 1 | Bus clock line as received |
| sda_i | input | 1 | Bus data line as received |
| sda_oe_o | output | 1 | High pulls the data line low (open drain) |
| chip_sel_i | input | 3 | Strapped device address |
| busy_i | input | 1 | Storage side is in a timed write |
| rd_addr_o | output | 11 | Read port address (equals the pointer) |
| rd_data_i | input | 8 | Read port data, combinational from rd_addr_o |
| wr_en_o | output | 1 | One-cycle strobe per accepted data byte |
| wr_addr_o | output | 11 | Address of the strobed byte |
| wr_data_o | output | 8 | Strobed data byte |
| commit_o | output | 1 | One-cycle strobe at a STOP that ends a write with data |

## Verification
The bench targets a page write that starts two bytes before a page end. A design that carried into bit 4 would write into the next page instead of wrapping to the page start. Sequential reads cross 0x7FF: a pointer narrower than 11 bits, or one that saturates, returns the wrong third byte. A control byte whose inverted select bit is sent uninverted must draw no ACK, and a bus address compare without the inversion would accept it. A START inserted after four data bits must resynchronise the frame, or the following control byte is misaligned and draws no ACK. A repeated START inside a random read must not raise the commit strobe. A bus monitor flags any change of the pull-down enable while SCL is high.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_CTRL  = 3'd1,
    ST_WADDR = 3'd2,
    ST_WDATA = 3'd3,
    ST_RDATA = 3'd4
  } eng_state_e;
endpackage

// File: rtl/i2cs_line_sync.sv
module i2cs_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic rise_o,
  output logic fall_o,
  output logic start_o,
  output logic stop_o
);
  // Synchronizer stages plus one history stage for edge detection.
  logic [STAGES:0] scl_q, sda_q, scl_d, sda_d;
  logic            scl_prev, sda_prev;

  always_comb begin
    scl_d = {scl_q[STAGES-1:0], scl_i};
    sda_d = {sda_q[STAGES-1:0], sda_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= '1;
      sda_q <= '1;
    end else begin
      scl_q <= scl_d;
      sda_q <= sda_d;
    end
  end

  always_comb begin
    scl_o    = scl_q[STAGES-1];
    sda_o    = sda_q[STAGES-1];
    scl_prev = scl_q[STAGES];
    sda_prev = sda_q[STAGES];
    rise_o   = scl_o & ~scl_prev;
    fall_o   = ~scl_o & scl_prev;
    start_o  = scl_o & scl_prev & sda_prev & ~sda_o;
    stop_o   = scl_o & scl_prev & ~sda_prev & sda_o;
  end
endmodule

// File: rtl/i2cs_bit_frame.sv
module i2cs_bit_frame (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       rise_i,
  input  logic       fall_i,
  input  logic       restart_i,
  input  logic       sda_i,
  output logic [3:0] cnt_o,
  output logic [7:0] byte_o,
  output logic       byte_done_o,
  output logic       ack_rise_o,
  output logic       frame_end_o
);
  localparam logic [3:0] LAST_DATA = 4'd7;
  localparam logic [3:0] ACK_POS   = 4'd8;
  localparam logic [3:0] END_POS   = 4'd9;

  logic [3:0] cnt_q, cnt_d;
  logic [7:0] sh_q, sh_d;
  logic       sh_en;

  always_comb begin
    cnt_d = cnt_q;
    sh_en = 1'b0;
    if (restart_i) begin
      cnt_d = '0;
    end else if (rise_i && cnt_q < ACK_POS) begin
      sh_en = 1'b1;
      cnt_d = cnt_q + 4'd1;
    end else if (rise_i && cnt_q == ACK_POS) begin
      cnt_d = END_POS;
    end else if (fall_i && cnt_q == END_POS) begin
      cnt_d = '0;
    end
    sh_d = {sh_q[6:0], sda_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      sh_q  <= '0;
    end else begin
      cnt_q <= cnt_d;
      if (sh_en) sh_q <= sh_d;
    end
  end

  always_comb begin
    cnt_o       = cnt_q;
    byte_o      = {sh_q[6:0], sda_i};
    byte_done_o = rise_i & ~restart_i & (cnt_q == LAST_DATA);
    ack_rise_o  = rise_i & ~restart_i & (cnt_q == ACK_POS);
    frame_end_o = fall_i & ~restart_i & (cnt_q == END_POS);
  end
endmodule

// File: rtl/i2cs_sda_drive.sv
module i2cs_sda_drive #(
  parameter int DLY = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic launch_i,
  input  logic low_i,
  input  logic clear_i,
  output logic sda_oe_o
);
  localparam int CW = (DLY < 2) ? 1 : $clog2(DLY);
  localparam logic [CW-1:0] LOAD = CW'(DLY - 1);

  logic          oe_q, oe_d, pend_q, pend_d, val_q, val_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    oe_d   = oe_q;
    pend_d = pend_q;
    val_d  = val_q;
    cnt_d  = cnt_q;
    if (clear_i) begin
      oe_d   = 1'b0;
      pend_d = 1'b0;
    end else if (launch_i) begin
      pend_d = 1'b1;
      val_d  = low_i;
      cnt_d  = LOAD;
    end else if (pend_q) begin
      if (cnt_q == '0) begin
        oe_d   = val_q;
        pend_d = 1'b0;
      end else begin
        cnt_d = cnt_q - CW'(1);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      oe_q   <= 1'b0;
      pend_q <= 1'b0;
      val_q  <= 1'b0;
      cnt_q  <= '0;
    end else begin
      oe_q   <= oe_d;
      pend_q <= pend_d;
      val_q  <= val_d;
      cnt_q  <= cnt_d;
    end
  end

  assign sda_oe_o = oe_q;
endmodule

// File: rtl/i2cs_slave.sv
module i2cs_slave #(
  parameter int          PAGE_W      = 4,
  parameter int          DRIVE_DLY   = 4,
  parameter int          SYNC_STAGES = 2,
  parameter logic [2:0]  SEL_INV     = 3'b010
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        scl_i,
  input  logic        sda_i,
  output logic        sda_oe_o,
  input  logic [2:0]  chip_sel_i,
  input  logic        busy_i,
  output logic [10:0] rd_addr_o,
  input  logic [7:0]  rd_data_i,
  output logic        wr_en_o,
  output logic [10:0] wr_addr_o,
  output logic [7:0]  wr_data_o,
  output logic        commit_o
);
  import i2cs_pkg::*;

  localparam int ADDR_W = 11;
  localparam int WORD_W = 8;
  localparam int BLK_W  = ADDR_W - WORD_W;

  logic       scl_s, sda_s, rise_evt, fall_evt, start_evt, stop_evt;
  logic [3:0] bit_cnt;
  logic [7:0] rx_byte;
  logic       byte_done, ack_rise, frame_end, restart;
  logic       launch, drv_low, drv_clear;

  i2cs_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .scl_i(scl_i), .sda_i(sda_i),
    .scl_o(scl_s), .sda_o(sda_s), .rise_o(rise_evt), .fall_o(fall_evt),
    .start_o(start_evt), .stop_o(stop_evt)
  );

  assign restart = start_evt | stop_evt;

  i2cs_bit_frame u_frame (
    .clk_i(clk_i), .rst_ni(rst_ni), .rise_i(rise_evt), .fall_i(fall_evt),
    .restart_i(restart), .sda_i(sda_s), .cnt_o(bit_cnt), .byte_o(rx_byte),
    .byte_done_o(byte_done), .ack_rise_o(ack_rise), .frame_end_o(frame_end)
  );

  i2cs_sda_drive #(.DLY(DRIVE_DLY)) u_drive (
    .clk_i(clk_i), .rst_ni(rst_ni), .launch_i(launch), .low_i(drv_low),
    .clear_i(drv_clear), .sda_oe_o(sda_oe_o)
  );

  // Protocol state
  eng_state_e        state_q, state_d;
  logic [ADDR_W-1:0] ptr_q, ptr_d;
  logic              ptr_en;
  logic              ack_q, ack_d;
  logic [7:0]        tx_q, tx_d;
  logic              txa_q, txa_d;
  logic              wrote_q, wrote_d;
  logic              wr_en_d, commit_d;
  logic [ADDR_W-1:0] wr_addr_d;
  logic [7:0]        wr_data_d;
  logic              sel_ok;

  // Marker bit, then select bits with configured inversion.
  assign sel_ok = rx_byte[7] & (rx_byte[6:4] == (chip_sel_i ^ SEL_INV));

  always_comb begin
    state_d   = state_q;
    ptr_d     = ptr_q;
    ptr_en    = 1'b0;
    ack_d     = ack_q;
    tx_d      = tx_q;
    txa_d     = txa_q;
    wrote_d   = wrote_q;
    wr_en_d   = 1'b0;
    wr_addr_d = wr_addr_o;
    wr_data_d = wr_data_o;
    commit_d  = 1'b0;
    launch    = 1'b0;
    drv_low   = 1'b0;
    drv_clear = 1'b0;

    if (start_evt) begin
      state_d   = ST_CTRL;
      wrote_d   = 1'b0;
      ack_d     = 1'b0;
      txa_d     = 1'b0;
      drv_clear = 1'b1;
    end else if (stop_evt) begin
      state_d   = ST_IDLE;
      commit_d  = wrote_q;
      wrote_d   = 1'b0;
      ack_d     = 1'b0;
      txa_d     = 1'b0;
      drv_clear = 1'b1;
    end else begin
      if (byte_done) begin
        unique case (state_q)
          ST_CTRL: begin
            if (sel_ok && !busy_i) begin
              ack_d  = 1'b1;
              ptr_en = 1'b1;
              ptr_d  = {rx_byte[BLK_W:1], ptr_q[WORD_W-1:0]};
              txa_d  = 1'b0;
              state_d = rx_byte[0] ? ST_RDATA : ST_WADDR;
            end else begin
              state_d = ST_IDLE;
            end
          end
          ST_WADDR: begin
            if (!busy_i) begin
              ack_d   = 1'b1;
              ptr_en  = 1'b1;
              ptr_d   = {ptr_q[ADDR_W-1:WORD_W], rx_byte};
              state_d = ST_WDATA;
            end else begin
              state_d = ST_IDLE;
            end
          end
          ST_WDATA: begin
            if (!busy_i) begin
              ack_d     = 1'b1;
              wr_en_d   = 1'b1;
              wr_addr_d = ptr_q;
              wr_data_d = rx_byte;
              wrote_d   = 1'b1;
              ptr_en    = 1'b1;
              ptr_d     = {ptr_q[ADDR_W-1:PAGE_W], ptr_q[PAGE_W-1:0] + PAGE_W'(1)};
            end else begin
              state_d = ST_IDLE;
            end
          end
          default: ;
        endcase
      end

      // Master acknowledge slot of a transmitted byte.
      if (ack_rise && state_q == ST_RDATA && txa_q) begin
        ptr_en = 1'b1;
        ptr_d  = ptr_q + ADDR_W'(1);
        if (sda_s) begin
          state_d = ST_IDLE;
          txa_d   = 1'b0;
        end
      end

      // Output scheduling on SCL falling edges.
      if (frame_end) begin
        launch = 1'b1;
        if (state_q == ST_RDATA) begin
          tx_d    = rd_data_i;
          drv_low = ~rd_data_i[7];
          txa_d   = 1'b1;
        end
      end else if (fall_evt && bit_cnt == 4'd8) begin
        launch  = 1'b1;
        drv_low = ack_q;
        ack_d   = 1'b0;
      end else if (fall_evt && bit_cnt != 4'd0 && state_q == ST_RDATA && txa_q) begin
        launch  = 1'b1;
        drv_low = ~tx_q[6];
        tx_d    = {tx_q[6:0], 1'b0};
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      ptr_q     <= '0;
      ack_q     <= 1'b0;
      tx_q      <= '0;
      txa_q     <= 1'b0;
      wrote_q   <= 1'b0;
      wr_en_o   <= 1'b0;
      wr_addr_o <= '0;
      wr_data_o <= '0;
      commit_o  <= 1'b0;
    end else begin
      state_q  <= state_d;
      if (ptr_en) ptr_q <= ptr_d;
      ack_q    <= ack_d;
      tx_q     <= tx_d;
      txa_q    <= txa_d;
      wrote_q  <= wrote_d;
      wr_en_o  <= wr_en_d;
      if (wr_en_d) begin
        wr_addr_o <= wr_addr_d;
        wr_data_o <= wr_data_d;
      end
      commit_o <= commit_d;
    end
  end

  assign rd_addr_o = ptr_q;
endmodule

// File: rtl/i2cs_slave_chk.sv
module i2cs_slave_chk (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  scl_s_i,
  input logic                  sda_oe_i,
  input i2cs_pkg::eng_state_e  state_i,
  input logic                  wr_en_i,
  input logic                  commit_i,
  input logic                  busy_i,
  input logic                  start_i
);
  import i2cs_pkg::*;

  a_r10_drive_scl_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sda_oe_i) |-> !scl_s_i);

  a_r9_idle_released: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_IDLE) |-> !sda_oe_i);

  a_r4_busy_no_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |-> !wr_en_i);

  a_r7_commit_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_i |=> !commit_i);

  a_r5_wr_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> !wr_en_i);

  a_r1_start_releases: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> !sda_oe_i);
endmodule

bind i2cs_slave i2cs_slave_chk chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .scl_s_i(scl_s), .sda_oe_i(sda_oe_o),
  .state_i(state_q), .wr_en_i(wr_en_o), .commit_i(commit_o),
  .busy_i(busy_i), .start_i(start_evt)
);

// File: tb/i2cs_slave_tb_top.sv
module i2cs_slave_tb_top;
  localparam int DLY = 4;
  localparam int Q = 15;
  localparam int H = 30;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_n;
  logic        scl_m, sda_m;
  logic [2:0]  pins;
  logic        busy;
  logic        sda_oe;
  logic        sda_line;
  logic [10:0] rd_addr, wr_addr;
  logic [7:0]  rd_data, wr_data;
  logic        wr_en, commit;
  logic [7:0]  mem [0:2047];

  assign sda_line = sda_m & ~sda_oe;
  assign rd_data  = mem[rd_addr];

  i2cs_slave #(.DRIVE_DLY(DLY)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .sda_oe_o(sda_oe), .chip_sel_i(pins), .busy_i(busy),
    .rd_addr_o(rd_addr), .rd_data_i(rd_data), .wr_en_o(wr_en),
    .wr_addr_o(wr_addr), .wr_data_o(wr_data), .commit_o(commit)
  );

  int n_chk = 0, n_err = 0;
  int wr_cnt = 0, commit_cnt = 0, r10_viol = 0, since_fall = 0;
  logic [10:0] wlog [0:7];
  logic        oe_prev = 1'b0;

  always @(posedge clk) begin
    if (wr_en) begin
      mem[wr_addr] <= wr_data;
      wlog[wr_cnt % 8] <= wr_addr;
      wr_cnt <= wr_cnt + 1;
    end
    if (commit) commit_cnt <= commit_cnt + 1;
    if (scl_m) since_fall <= 0; else since_fall <= since_fall + 1;
    oe_prev <= sda_oe;
    if (rst_n && (sda_oe != oe_prev) && (scl_m || since_fall < DLY)) r10_viol <= r10_viol + 1;
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [7:0] ctrl(input logic [2:0] blk, input logic rw);
    return {1'b1, pins[2], ~pins[1], pins[0], blk, rw};
  endfunction

  task automatic bus_start();
    sda_m = 1'b1; wclk(Q); scl_m = 1'b1; wclk(H);
    sda_m = 1'b0; wclk(H); scl_m = 1'b0; wclk(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wclk(Q); scl_m = 1'b1; wclk(H); sda_m = 1'b1; wclk(H);
  endtask

  task automatic send_bit(input logic b);
    sda_m = b; wclk(Q); scl_m = 1'b1; wclk(H); scl_m = 1'b0; wclk(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic acked);
    logic s0, s1;
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    sda_m = 1'b1; wclk(Q); scl_m = 1'b1;
    wclk(2); s0 = sda_line; wclk(H - 4); s1 = sda_line; wclk(2);
    scl_m = 1'b0; wclk(Q);
    acked = !s0 && !s1;
  endtask

  task automatic recv_byte(input logic m_ack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      wclk(Q); scl_m = 1'b1; wclk(H / 2); b[i] = sda_line; wclk(H / 2);
      scl_m = 1'b0; wclk(Q);
    end
    sda_m = m_ack ? 1'b0 : 1'b1; wclk(Q); scl_m = 1'b1; wclk(H);
    scl_m = 1'b0; wclk(Q); sda_m = 1'b1;
  endtask

  task automatic t_reset();
    chk("R1", "sda_oe after reset", sda_oe, 0);
    chk("R5", "wr_en after reset", wr_en, 0);
    chk("R7", "commit after reset", commit, 0);
  endtask

  task automatic t_byte_write();
    logic a; int w0 = wr_cnt, c0 = commit_cnt;
    bus_start();
    send_byte(ctrl(3'd3, 1'b0), a); chk("R2", "ctrl ack", a, 1);
    send_byte(8'h5A, a);            chk("R3", "addr ack", a, 1);
    send_byte(8'hC3, a);            chk("R3", "data ack", a, 1);
    bus_stop(); wclk(5);
    chk("R5", "write count", wr_cnt - w0, 1);
    chk("R5", "write addr", wlog[w0 % 8], 11'h35A);
    chk("R5", "written data", mem[11'h35A], 8'hC3);
    chk("R7", "commit count", commit_cnt - c0, 1);
  endtask

  task automatic t_bad_select();
    logic a; logic [7:0] c; int w0 = wr_cnt;
    c = ctrl(3'd0, 1'b0); c[5] = ~c[5];
    bus_start();
    send_byte(c, a);     chk("R2", "uninverted select nack", a, 0);
    send_byte(8'h00, a); chk("R2", "ignored byte nack", a, 0);
    send_byte(8'h11, a); chk("R2", "ignored data nack", a, 0);
    bus_stop(); wclk(5);
    chk("R2", "no write when unselected", wr_cnt - w0, 0);
    c = ctrl(3'd0, 1'b0); c[7] = 1'b0;
    bus_start();
    send_byte(c, a);     chk("R2", "marker bit zero nack", a, 0);
    bus_stop();
  endtask

  task automatic t_busy_poll();
    logic a; int c0 = commit_cnt;
    busy = 1'b1;
    bus_start(); send_byte(ctrl(3'd0, 1'b0), a); chk("R4", "nack while busy", a, 0);
    bus_stop();
    busy = 1'b0;
    bus_start(); send_byte(ctrl(3'd0, 1'b0), a); chk("R4", "ack after busy", a, 1);
    bus_stop(); wclk(5);
    chk("R7", "no commit without data", commit_cnt - c0, 0);
  endtask

  task automatic t_page_write();
    logic a; int w0 = wr_cnt, c0 = commit_cnt;
    bus_start();
    send_byte(ctrl(3'd1, 1'b0), a);
    send_byte(8'h0E, a);
    send_byte(8'h11, a); send_byte(8'h22, a); send_byte(8'h33, a); send_byte(8'h44, a);
    chk("R3", "last page byte ack", a, 1);
    bus_stop(); wclk(5);
    chk("R6", "page write count", wr_cnt - w0, 4);
    chk("R6", "page addr 0", wlog[(w0 + 0) % 8], 11'h10E);
    chk("R6", "page addr 1", wlog[(w0 + 1) % 8], 11'h10F);
    chk("R6", "page addr 2 wraps", wlog[(w0 + 2) % 8], 11'h100);
    chk("R6", "page addr 3", wlog[(w0 + 3) % 8], 11'h101);
    chk("R7", "page commit", commit_cnt - c0, 1);
  endtask

  task automatic t_random_read();
    logic a; logic [7:0] d; int c0 = commit_cnt, bad = 0;
    bus_start();
    send_byte(ctrl(3'd2, 1'b0), a);
    send_byte(8'h34, a);
    bus_start();
    send_byte(ctrl(3'd2, 1'b1), a); chk("R8", "read ctrl ack", a, 1);
    recv_byte(1'b0, d);             chk("R8", "random read data", d, mem[11'h234]);
    for (int i = 0; i < 40; i++) begin
      if (sda_oe) bad++;
      wclk(1);
    end
    chk("R9", "released after nack", bad, 0);
    bus_stop(); wclk(5);
    chk("R7", "repeated start no commit", commit_cnt - c0, 0);
  endtask

  task automatic t_current_read();
    logic a; logic [7:0] d;
    bus_start();
    send_byte(ctrl(3'd2, 1'b1), a); chk("R8", "current read ack", a, 1);
    recv_byte(1'b0, d);             chk("R8", "current read next addr", d, mem[11'h235]);
    bus_stop();
  endtask

  task automatic t_seq_wrap();
    logic a; logic [7:0] d;
    bus_start();
    send_byte(ctrl(3'd7, 1'b0), a);
    send_byte(8'hFE, a);
    bus_start();
    send_byte(ctrl(3'd7, 1'b1), a);
    recv_byte(1'b1, d); chk("R9", "seq byte 0x7FE", d, mem[11'h7FE]);
    recv_byte(1'b1, d); chk("R9", "seq byte 0x7FF", d, mem[11'h7FF]);
    recv_byte(1'b0, d); chk("R9", "seq wrap to 0x000", d, mem[11'h000]);
    bus_stop();
  endtask

  task automatic t_mid_start();
    logic a; logic [7:0] d; int w0 = wr_cnt;
    bus_start();
    send_byte(ctrl(3'd4, 1'b0), a);
    send_bit(1'b1); send_bit(1'b0); send_bit(1'b1); send_bit(1'b0);
    bus_start();
    send_byte(ctrl(3'd4, 1'b0), a); chk("R1", "ctrl ack after mid-byte start", a, 1);
    send_byte(8'h10, a);            chk("R1", "addr ack after resync", a, 1);
    bus_start();
    send_byte(ctrl(3'd4, 1'b1), a);
    recv_byte(1'b0, d);             chk("R1", "read after resync", d, mem[11'h410]);
    bus_stop(); wclk(5);
    chk("R1", "no write from partial byte", wr_cnt - w0, 0);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual=timeout expected=done");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 2048; i++) mem[i] = 8'((i * 37 + 11) ^ (i >> 8));
    rst_n = 1'b0; scl_m = 1'b1; sda_m = 1'b1; pins = 3'b101; busy = 1'b0;
    wclk(5);
    t_reset();
    rst_n = 1'b1;
    wclk(10);
    t_byte_write();
    t_bad_select();
    t_busy_poll();
    t_page_write();
    t_random_read();
    t_current_read();
    t_seq_wrap();
    t_mid_start();
    chk("R10", "drive changes outside SCL low window", r10_viol, 0);
    finish_run();
  end
endmodule